// File: doc/BRIEF.md
# Modulo 2^n+1 Residue Adder

This block adds two residues modulo m = 2^n + 1, where n is a parameter. Both operands and the result are h = n + 1 bits wide, and each operand must already be below m. Residue number systems and some block-cipher round functions use this kind of arithmetic.

Two sums are formed side by side. One adder produces the plain sum x + y. A three-operand adder produces the same sum plus a fixed correction constant. The carry-out of the corrected sum alone chooses which of the two sums reaches the output. No second pass is needed, so the critical path is one carry chain plus a multiplexer.

The result can leave through an output register that loads only on valid input, or it can leave directly as combinational logic. A parameter chooses between the two. A valid flag travels with the result.

Top module: `mod2n1_adder`

## Requirements
- R1: For every pair x, y with both operands below m = 2^n + 1, the result equals (x + y) mod m. Operands and result are n+1 bits wide.
- R2: When x + y < m, the result is exactly x + y (the uncorrected sum).
- R3: When x + y >= m, the result is x + y − m. This includes x + y = m, which gives 0.
- R4: Every result presented with valid high is below m.
- R5: With the output register enabled, sum_o and out_valid show the input of the previous rising clock edge. out_valid is high exactly when in_valid was high at that edge.
- R6: A synchronous active-high rst clears out_valid and sum_o to 0 at the next rising edge.
- R7: With the output register disabled, sum_o shows the residue of the present inputs in the same cycle, and out_valid equals in_valid.
- R8: With the output register enabled, an edge at which in_valid is low leaves sum_o unchanged, whatever the operand inputs are.
- R9: The largest pair, x = y = m − 1, gives m − 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| x_i | input | N_BITS+1 | First residue, below m |
| y_i | input | N_BITS+1 | Second residue, below m |
| out_valid | output | 1 | sum_o holds a fresh result |
| sum_o | output | N_BITS+1 | (x_i + y_i) mod m |

## Verification
A small modulus, m = 17, is swept exhaustively over all 289 operand pairs. The bench runs one instance with the output register and one without. Pairs whose sum stays below m exercise the plain path. Pairs whose sum equals or exceeds m exercise the corrected path, with x + y = m and x = y = m − 1 as the two edges of the selection. Idle cycles that carry changed operands separate a register that holds its value from one that loads blindly. A reset applied during valid input confirms that the cleared state takes priority.

// File: rtl/mod2n1_pkg.sv
package mod2n1_pkg;

  // Modulus 2^n + 1 for a given n
  function automatic longint unsigned mod_value(input int unsigned n);
    return (64'd1 << n) + 64'd1;
  endfunction

  // Two's-complement correction term over n+2 bits: 2^(n+2) - m
  function automatic longint unsigned corr_value(input int unsigned n);
    return (64'd1 << (n + 2)) - mod_value(n);
  endfunction

endpackage

// File: rtl/m2n1_ripple.sv
module m2n1_ripple #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    assign p        = a_i[i] ^ b_i[i];
    assign sum_o[i] = p ^ cy[i];
    assign cy[i+1]  = (a_i[i] & b_i[i]) | (p & cy[i]);
  end

  assign cout_o = cy[W];
endmodule

// File: rtl/m2n1_csa3.sv
module m2n1_csa3 #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         spill_o
);
  logic [W-1:0] ps;
  logic [W-1:0] pc;
  logic [W:0]   tot;

  // Carry-save row: three operands reduce to a sum vector and a carry vector
  for (genvar i = 0; i < W; i++) begin : g_csa
    assign ps[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    assign pc[i] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
  end

  // Final carry-propagate stage, one bit wider than the operands
  m2n1_ripple #(.W(W + 1)) u_cpa (
    .a_i   ({1'b0, ps}),
    .b_i   ({pc, 1'b0}),
    .sum_o (tot),
    .cout_o(spill_o)
  );

  assign sum_o  = tot[W-1:0];
  assign cout_o = tot[W];
endmodule

// File: rtl/m2n1_pick.sv
module m2n1_pick #(
  parameter int unsigned H = 8
) (
  input  logic [H-1:0] plain_i,
  input  logic [H-1:0] corr_i,
  input  logic         wrap_i,
  output logic [H-1:0] res_o
);
  always_comb begin
    if (wrap_i) res_o = corr_i;
    else        res_o = plain_i;
  end
endmodule

// File: rtl/mod2n1_adder.sv
module mod2n1_adder
  import mod2n1_pkg::*;
#(
  parameter int unsigned N_BITS  = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [N_BITS:0]   x_i,
  input  logic [N_BITS:0]   y_i,
  output logic              out_valid,
  output logic [N_BITS:0]   sum_o
);
  localparam int unsigned H = N_BITS + 1;
  localparam int unsigned W = H + 1;
  localparam logic [H-1:0] MODV = H'(mod_value(N_BITS));
  localparam logic [W-1:0] CORR = W'(corr_value(N_BITS));

  logic [H-1:0] plain_sum;
  logic         plain_cout;
  logic [W-1:0] corr_sum;
  logic         corr_cout;
  logic         corr_spill;
  logic [H-1:0] res;

  // Uncorrected path
  m2n1_ripple #(.W(H)) u_plain (
    .a_i   (x_i),
    .b_i   (y_i),
    .sum_o (plain_sum),
    .cout_o(plain_cout)
  );

  // Corrected path, evaluated concurrently
  m2n1_csa3 #(.W(W)) u_corr (
    .a_i    ({1'b0, x_i}),
    .b_i    ({1'b0, y_i}),
    .c_i    (CORR),
    .sum_o  (corr_sum),
    .cout_o (corr_cout),
    .spill_o(corr_spill)
  );

  m2n1_pick #(.H(H)) u_pick (
    .plain_i(plain_sum),
    .corr_i (corr_sum[H-1:0]),
    .wrap_i (corr_cout),
    .res_o  (res)
  );

  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [H-1:0] sum_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        sum_q <= '0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) sum_q <= res;
      end
    end

    assign out_valid = vld_q;
    assign sum_o     = sum_q;

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R5
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(sum_o)); // R8
  end else begin : g_comb
    assign out_valid = in_valid;
    assign sum_o     = res;
  end

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (x_i < MODV) && (y_i < MODV)); // R1
  AST_PLAIN_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    in_valid && !corr_cout |-> !plain_cout); // R2
  AST_CORR_FITS: assert property (@(posedge clk) disable iff (rst)
    in_valid && corr_cout |-> !corr_sum[H]); // R3
  AST_CSA_NO_SPILL: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !corr_spill); // R3
  AST_RES_BELOW_M: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (res < MODV)); // R4
endmodule

// File: tb/tb_mod2n1_adder.sv
module tb_mod2n1_adder;
  localparam int unsigned NB = 4;
  localparam int MODV = (1 << NB) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NB:0] x = '0;
  logic [NB:0] y = '0;
  logic        ov_r, ov_c;
  logic [NB:0] s_r, s_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mod2n1_adder #(.N_BITS(NB), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_i(x), .y_i(y),
    .out_valid(ov_r), .sum_o(s_r)
  );

  mod2n1_adder #(.N_BITS(NB), .REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_i(x), .y_i(y),
    .out_valid(ov_c), .sum_o(s_c)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset valid", int'(ov_r), 0);
    chk("R6 reset sum", int'(s_r), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int a = 0; a < MODV; a++) begin
      for (int b = 0; b < MODV; b++) begin
        int e;
        e = (a + b) % MODV;
        @(negedge clk);
        x = (NB+1)'(a);
        y = (NB+1)'(b);
        in_valid = 1'b1;
        #1;
        if (a + b < MODV) chk("R2 plain path", int'(s_c), a + b);
        else              chk("R3 corrected path", int'(s_c), a + b - MODV);
        chk("R7 comb valid", int'(ov_c), 1);
        if (a == MODV - 1 && b == MODV - 1) chk("R9 max pair", int'(s_c), MODV - 2);
        @(posedge clk);
        #1;
        chk("R1 registered residue", int'(s_r), e);
        chk("R5 registered valid", int'(ov_r), 1);
        chk("R4 below m", int'(s_r < (NB+1)'(MODV)), 1);
      end
    end

    // Idle cycle with changed operands
    @(negedge clk);
    in_valid = 1'b0;
    x = 5'd3;
    y = 5'd5;
    #1;
    chk("R7 comb idle valid", int'(ov_c), 0);
    chk("R7 comb idle sum", int'(s_c), 8);
    @(posedge clk);
    #1;
    chk("R5 idle valid", int'(ov_r), 0);
    chk("R8 hold sum", int'(s_r), MODV - 2);

    // Reset during valid input
    @(negedge clk);
    in_valid = 1'b1;
    x = 5'd1;
    y = 5'd2;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R6 reset priority valid", int'(ov_r), 0);
    chk("R6 reset priority sum", int'(s_r), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R5 after reset", int'(s_r), 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule